// File: doc/BRIEF.md
# Indirect Management Register Bridge

This block sits behind a management bus slave and gives the host access to an internal bank of device registers, organised as 32 device addresses by 32 registers of 16 bits each. When the strap input is zero the bank is mapped flat: every bus address and register number pair selects one internal word directly. When the strap is nonzero the block answers only on the bus address equal to the strap. It then exposes a two-register window: a command register at offset 0 and a data register at offset 1.

In the windowed mode the host writes a command word that carries an opcode, an internal device address and a register number. The block sets a busy flag, waits a fixed access latency, performs the internal read or write and then clears busy. For a write the host loads the data register before issuing the command. After a read the result is left in the data register. Host accesses arrive as parallel read and write strobes, and each read returns its data one cycle later with a valid flag.

Top module: `smi_indirect_bridge`

## Requirements
- R1: With the strap equal to 0, a host write to (bus address, register) stores the word at internal device = bus address, register = register number. A host read there returns that word. Busy never rises in this mode.
- R2: With a nonzero strap, accesses to any other bus address get no response (the valid flag stays 0), and writes to that address change nothing.
- R3: Reading the command register returns busy in bit 15 and the last accepted command in bits 14:0. An accepted command makes busy read 1 for exactly LATENCY (default 4) consecutive cycles after the accepting edge, and 0 afterwards.
- R4: A command whose bits 15:10 equal 6'b100110 (0x9800 pattern) reads the internal word at device = bits 9:5 and register = bits 4:0. Once busy clears, the result is in the data register.
- R5: A command whose bits 15:10 equal 6'b100101 (0x9400 pattern) writes the data register's value into the word at device = bits 9:5 and register = bits 4:0.
- R6: A command write while busy is 1 is ignored. The command register keeps its value, and neither the internal word it names nor the data register is touched.
- R7: A command whose bits 15:10 match neither opcode still runs the busy period and then clears busy. It accesses no internal word and leaves the data register unchanged.
- R8: A data register write while busy is 1 is ignored.
- R9: After reset the valid flag and read data are 0 and busy is 0. A responded read raises the valid flag exactly one cycle after the read strobe. Windowed reads of offsets other than 0 and 1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_addr | input | 5 | Own bus address; 0 selects flat mapping |
| bus_addr | input | 5 | Bus address of the host access |
| bus_reg | input | 5 | Register number of the host access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a responded read |

## Verification
A vector table of six words is written through the window, with corner addresses (0,0) and (31,31), and with patterns of all ones, a single one bit, and alternating bits. The words are then read back both through the window and through flat mapping. This separates a swapped device and register field, or wrong bit positions, from a correct two-level decode. The busy period is measured by back-to-back polling on every command, which exposes a latency off by one in either direction. Directed cases issue a second command or a data load while busy, an unknown opcode, a foreign bus address and an unused offset. Each case shows whether the guard really blocks the stored state rather than only the flag.

// File: rtl/smi_indirect_bridge.sv
module smi_indirect_bridge #(
  parameter int DEV_W   = 5,
  parameter int REG_W   = 5,
  parameter int DATA_W  = 16,
  parameter int LATENCY = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEV_W-1:0]  strap_addr,
  input  logic [DEV_W-1:0]  bus_addr,
  input  logic [REG_W-1:0]  bus_reg,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_rvalid
);
  localparam int IDX_W = DEV_W + REG_W;
  localparam int WORDS = 1 << IDX_W;
  localparam int OPC_W = DATA_W - IDX_W;
  localparam int CNT_W = $clog2(LATENCY + 1);
  localparam logic [OPC_W-1:0] OPC_RD = OPC_W'(6'h26);
  localparam logic [OPC_W-1:0] OPC_WR = OPC_W'(6'h25);

  logic [DATA_W-1:0] mem [WORDS];
  logic [DATA_W-1:0] cmd_q, data_q, rd_mux;
  logic [CNT_W-1:0]  cnt;
  logic              busy;

  wire direct  = (strap_addr == '0);
  wire hit     = !direct && (bus_addr == strap_addr);
  wire sel_cmd = hit && (bus_reg == REG_W'(0));
  wire sel_dat = hit && (bus_reg == REG_W'(1));
  wire accept  = bus_wr && sel_cmd && !busy;
  wire finish  = busy && (cnt == '0);
  wire [OPC_W-1:0] opc = cmd_q[DATA_W-1:IDX_W];
  wire [IDX_W-1:0] tgt = cmd_q[IDX_W-1:0];
  wire [IDX_W-1:0] flat_idx = {bus_addr, bus_reg};

  always_ff @(posedge clk) begin
    if (direct && bus_wr)
      mem[flat_idx] <= bus_wdata;
    else if (finish && opc == OPC_WR)
      mem[tgt] <= data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (accept) begin
      cmd_q <= bus_wdata;
      busy  <= 1'b1;
      cnt   <= CNT_W'(LATENCY - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      data_q <= '0;
    else if (finish && opc == OPC_RD)
      data_q <= mem[tgt];
    else if (bus_wr && sel_dat && !busy)
      data_q <= bus_wdata;
  end

  always_comb begin
    rd_mux = '0;
    if (direct)       rd_mux = mem[flat_idx];
    else if (sel_cmd) rd_mux = {busy, cmd_q[DATA_W-2:0]};
    else if (sel_dat) rd_mux = data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_rd && (direct || hit);
      if (bus_rd && (direct || hit)) bus_rdata <= rd_mux;
    end
  end

  logic [CNT_W:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  initial AST_LATENCY_POS: assert (LATENCY >= 1); // R3

  AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel_cmd && !busy |=> busy); // R3
  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(busy_run) == (CNT_W+1)'(LATENCY - 1)); // R3
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_run < (CNT_W+1)'(LATENCY)); // R3
  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && bus_wr && sel_cmd |=> $stable(cmd_q)); // R6
  AST_FLAT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    direct && !busy |=> !busy); // R1
  AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !direct && bus_addr != strap_addr && bus_rd |=> !bus_rvalid); // R2
  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_rd)); // R9
endmodule

// File: tb/smi_indirect_bridge_tb.sv
module smi_indirect_bridge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam logic [4:0] S = 5'd9;
  localparam int NV = 6;
  localparam logic [25:0] VEC [NV] = '{
    {5'd0,  5'd0,  16'h1234}, {5'd31, 5'd31, 16'hBEEF},
    {5'd3,  5'd17, 16'h0001}, {5'd17, 5'd3,  16'hFFFF},
    {5'd8,  5'd1,  16'hA55A}, {5'd1,  5'd8,  16'h5AA5}};

  logic clk = 0, rst_n = 0;
  logic [4:0] strap_addr = S, bus_addr = '0, bus_reg = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  int checks = 0, failures = 0;
  logic [15:0] expd [NV];

  smi_indirect_bridge u_dut (.clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
    .bus_addr(bus_addr), .bus_reg(bus_reg), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwrite(logic [4:0] a, logic [4:0] r, logic [15:0] d);
    bus_addr = a; bus_reg = r; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic hread(logic [4:0] a, logic [4:0] r, output logic [15:0] d, output logic v);
    bus_addr = a; bus_reg = r; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata; v = bus_rvalid;
  endtask

  task automatic run_cmd(string req, logic [15:0] cmd);
    logic [15:0] d; logic v; int polls;
    hwrite(S, 5'd0, cmd);
    polls = 0;
    for (int i = 0; i < 32; i++) begin
      hread(S, 5'd0, d, v);
      if (!d[15]) break;
      polls++;
    end
    check(req, 16'(polls), 16'(LAT));
  endtask

  function automatic logic [15:0] rd_cmd(logic [25:0] e);
    return 16'h9800 | {6'd0, e[25:16]};
  endfunction
  function automatic logic [15:0] wr_cmd(logic [25:0] e);
    return 16'h9400 | {6'd0, e[25:16]};
  endfunction

  initial begin
    logic [15:0] d; logic v;
    for (int i = 0; i < NV; i++) expd[i] = VEC[i][15:0];
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 reset rvalid", 16'(bus_rvalid), 16'd0);
    check("R9 reset rdata", bus_rdata, 16'd0);
    hread(S, 5'd0, d, v);
    check("R3 idle cmd reg", d, 16'd0);
    check("R9 rvalid after read", 16'(v), 16'd1);

    for (int i = 0; i < NV; i++) begin
      hwrite(S, 5'd1, VEC[i][15:0]);
      run_cmd("R3 write busy span", wr_cmd(VEC[i]));
    end
    for (int i = 0; i < NV; i++) begin
      run_cmd("R3 read busy span", rd_cmd(VEC[i]));
      hread(S, 5'd1, d, v);
      check("R4 R5 window readback", d, VEC[i][15:0]);
    end

    hwrite(S, 5'd0, rd_cmd(VEC[1]));
    hwrite(S, 5'd0, wr_cmd(VEC[2]));
    repeat (LAT + 1) @(negedge clk);
    hread(S, 5'd0, d, v);
    check("R6 cmd reg kept", d, rd_cmd(VEC[1]) & 16'h7FFF);
    hread(S, 5'd1, d, v);
    check("R6 data from first cmd", d, 16'hBEEF);
    run_cmd("R3", rd_cmd(VEC[2]));
    hread(S, 5'd1, d, v);
    check("R6 target untouched", d, 16'h0001);

    hwrite(S, 5'd1, 16'h1111);
    hwrite(S, 5'd0, wr_cmd(VEC[3]));
    hwrite(S, 5'd1, 16'h2222);
    repeat (LAT + 1) @(negedge clk);
    hread(S, 5'd1, d, v);
    check("R8 data reg kept", d, 16'h1111);
    expd[3] = 16'h1111;
    run_cmd("R3", rd_cmd(VEC[3]));
    hread(S, 5'd1, d, v);
    check("R8 written value", d, 16'h1111);

    hwrite(S, 5'd1, 16'h7777);
    run_cmd("R7 unknown op busy clears", 16'hA000 | {6'd0, VEC[0][25:16]});
    hread(S, 5'd1, d, v);
    check("R7 data reg unchanged", d, 16'h7777);
    hwrite(S, 5'd0, 16'hA000 | {6'd0, VEC[0][25:16]});
    repeat (LAT + 1) @(negedge clk);
    run_cmd("R3", rd_cmd(VEC[0]));
    hread(S, 5'd1, d, v);
    check("R7 word unchanged", d, 16'h1234);

    hread(S + 5'd1, 5'd0, d, v);
    check("R2 foreign no response", 16'(v), 16'd0);
    hwrite(S + 5'd1, 5'd1, 16'h3333);
    hread(S, 5'd1, d, v);
    check("R2 foreign write ignored", d, 16'h1234);
    hread(S, 5'd7, d, v);
    check("R9 unused offset valid", 16'(v), 16'd1);
    check("R9 unused offset zero", d, 16'd0);

    strap_addr = 5'd0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      hread(VEC[i][25:21], VEC[i][20:16], d, v);
      check("R1 flat read", d, expd[i]);
    end
    hwrite(5'd12, 5'd12, 16'hCAFE);
    hread(5'd12, 5'd12, d, v);
    check("R1 flat write", d, 16'hCAFE);
    check("R1 flat valid", 16'(v), 16'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule